// File: doc/BRIEF.md
# Fetch and Next-PC Sequencer

This block paces a small 32-bit load/store core whose instruction memory takes two clock cycles to return a word. Every instruction occupies a fixed slot of three cycles. In the first two cycles the word is still on its way, and the block holds the program counter and the memory word address steady. In the third cycle the instruction executes and a one-cycle execute strobe is raised. At the end of that cycle the program counter takes its next value.

The next value comes from one of three sources: the register operand of a register-indirect jump, the target of a taken conditional branch, or the address that follows. The branch target is always formed from the counter value of the instruction being executed, because the counter cannot move during the fetch wait. The decoder, ALU, register file and memory model sit outside the block. The block takes their decoded control bits and operands as inputs. It gates the decoded register write with the execute strobe, so each instruction writes back exactly once.

Top module: `fetch_seq`

## Requirements
- R1: `phase` runs 0, 1, 2, 0, … advancing by one each clock, and is 0 after reset.
- R2: `exec_stb` is 1 exactly when `phase` is 2 and 0 in phases 0 and 1.
- R3: When `exec_stb` is 1, `jr_sel` is 0 and no branch is taken, `pc` becomes `pc + 4` at the end of phase 2.
- R4: When `exec_stb` is 1 and `jr_sel` is 1, `pc` becomes `rs_value`, whatever the branch inputs are (the jump has the highest priority).
- R5: An equal-branch (`beq_sel`=1) is taken when `alu_zero`=1. The new `pc` is `pc + 4 + (sign-extended br_imm << 2)`, using the `pc` of the executing instruction. With `alu_zero`=0 it falls through to `pc + 4`.
- R6: A not-equal branch (`bne_sel`=1) is taken when `alu_zero`=0, with the same target as R5. With `alu_zero`=1 it falls through to `pc + 4`.
- R7: `pc` changes only at the end of phase 2. All control and operand inputs presented in phases 0 and 1 have no effect on `pc`.
- R8: `rf_we` equals `rf_we_dec` while `exec_stb` is 1 and is 0 otherwise.
- R9: `imem_addr` equals `pc[15:2]`, a 14-bit word address.
- R10: A synchronous, active-high `rst` sets `pc` to 0 and `phase` to 0 at the next clock edge, from any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| jr_sel | input | 1 | Decoded register-indirect jump |
| beq_sel | input | 1 | Decoded branch-if-equal |
| bne_sel | input | 1 | Decoded branch-if-not-equal |
| alu_zero | input | 1 | ALU result-is-zero flag |
| rs_value | input | 32 | Source register operand (jump target) |
| br_imm | input | 16 | Branch offset in words, two's complement |
| rf_we_dec | input | 1 | Decoded register-file write request |
| pc | output | 32 | Program counter of the current instruction |
| imem_addr | output | 14 | Instruction memory word address |
| exec_stb | output | 1 | Execute-phase strobe |
| rf_we | output | 1 | Gated register-file write enable |
| phase | output | 2 | Slot phase 0..2 |

## Verification
The bench runs all sixteen combinations of the jump, equal-branch, not-equal-branch and zero inputs. Each combination is tried against offsets of zero, plus one, minus one and both signed extremes. This separates priority mistakes, inverted branch conditions and sign-extension faults from one another. During the two wait phases of every slot, the bench drives a competing jump and a write request. A counter that moves early, or a write that is not gated, then shows up as a wrong `pc`, a wrong address or a stray `rf_we`. A reset applied in the middle of a slot checks that the phase and the counter both restart.

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int PC_W = 32,
  parameter int IMM_W = 16,
  parameter int MADDR_W = 14,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               jr_sel,
  input  logic               beq_sel,
  input  logic               bne_sel,
  input  logic               alu_zero,
  input  logic [PC_W-1:0]    rs_value,
  input  logic [IMM_W-1:0]   br_imm,
  input  logic               rf_we_dec,
  output logic [PC_W-1:0]    pc,
  output logic [MADDR_W-1:0] imem_addr,
  output logic               exec_stb,
  output logic               rf_we,
  output logic [1:0]         phase
);
  localparam int WLSB = 2;
  localparam int EXT_W = PC_W - IMM_W - WLSB;
  localparam logic [1:0] LAST = 2'd2;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [1:0]      phase_q;
  logic [PC_W-1:0] pc_q, pc_seq, br_off, pc_next;
  logic            taken;

  assign exec_stb  = (phase_q == LAST);
  assign phase     = phase_q;
  assign pc        = pc_q;
  assign imem_addr = pc_q[WLSB +: MADDR_W];
  assign rf_we     = rf_we_dec & exec_stb;

  assign pc_seq  = pc_q + STEP;
  assign br_off  = {{EXT_W{br_imm[IMM_W-1]}}, br_imm, {WLSB{1'b0}}};
  assign taken   = (beq_sel & alu_zero) | (bne_sel & ~alu_zero);
  assign pc_next = jr_sel ? rs_value : (taken ? pc_seq + br_off : pc_seq);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      pc_q    <= RESET_PC;
    end else begin
      phase_q <= exec_stb ? 2'd0 : phase_q + 2'd1;
      if (exec_stb) pc_q <= pc_next;
    end
  end

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    phase_q == LAST |=> phase_q == 2'd0); // R1
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    phase_q != LAST |=> phase_q == $past(phase_q) + 2'd1); // R1
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    exec_stb |=> !exec_stb); // R2
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !exec_stb |=> $stable(pc_q)); // R7
  AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (rst)
    exec_stb && !jr_sel && !beq_sel && !bne_sel |=> pc_q == $past(pc_q) + STEP); // R3
  AST_JR_NEXT: assert property (@(posedge clk) disable iff (rst)
    exec_stb && jr_sel |=> pc_q == $past(rs_value)); // R4
  AST_BEQ_NEXT: assert property (@(posedge clk) disable iff (rst)
    exec_stb && !jr_sel && beq_sel && alu_zero |=> pc_q == $past(pc_q) + STEP + $past(br_off)); // R5
  AST_BNE_NEXT: assert property (@(posedge clk) disable iff (rst)
    exec_stb && !jr_sel && bne_sel && !alu_zero |=> pc_q == $past(pc_q) + STEP + $past(br_off)); // R6
  AST_WE_GATE: assert property (@(posedge clk) disable iff (rst)
    !exec_stb |-> !rf_we); // R8
  AST_RESET: assert property (@(posedge clk)
    rst |=> pc_q == RESET_PC && phase_q == 2'd0); // R10
endmodule

// File: tb/sim_fetch_seq.sv
module sim_fetch_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic jr_sel = 0, beq_sel = 0, bne_sel = 0, alu_zero = 0, rf_we_dec = 0;
  logic [31:0] rs_value = '0;
  logic [15:0] br_imm = '0;
  logic [31:0] pc;
  logic [13:0] imem_addr;
  logic exec_stb, rf_we;
  logic [1:0] phase;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_pc = '0;

  always #4 clk = ~clk;

  fetch_seq u0 (
    .clk(clk), .rst(rst), .jr_sel(jr_sel), .beq_sel(beq_sel), .bne_sel(bne_sel),
    .alu_zero(alu_zero), .rs_value(rs_value), .br_imm(br_imm), .rf_we_dec(rf_we_dec),
    .pc(pc), .imem_addr(imem_addr), .exec_stb(exec_stb), .rf_we(rf_we), .phase(phase)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic slot(input logic j, input logic b, input logic n, input logic z,
                      input logic [31:0] rs, input logic [15:0] imm, input logic we);
    logic [31:0] nxt;
    string tag;
    for (int p = 0; p < 2; p++) begin
      jr_sel = 1; beq_sel = 1; bne_sel = 1; alu_zero = p[0];
      rs_value = ~exp_pc; br_imm = 16'h7FFF; rf_we_dec = 1;
      #1;
      chk("R1 phase", 32'(phase), 32'(p));
      chk("R2 exec_stb low", 32'(exec_stb), 32'd0);
      chk("R8 rf_we gated", 32'(rf_we), 32'd0);
      chk("R7 pc held", pc, exp_pc);
      chk("R9 imem_addr", 32'(imem_addr), 32'(exp_pc[15:2]));
      tick;
    end
    jr_sel = j; beq_sel = b; bne_sel = n; alu_zero = z;
    rs_value = rs; br_imm = imm; rf_we_dec = we;
    #1;
    chk("R1 phase", 32'(phase), 32'd2);
    chk("R2 exec_stb high", 32'(exec_stb), 32'd1);
    chk("R8 rf_we pass", 32'(rf_we), 32'(we));
    if (j) begin
      nxt = rs; tag = "R4 jr target";
    end else if ((b && z) || (n && !z)) begin
      nxt = exp_pc + 32'd4 + 32'(int'($signed(imm)) * 4);
      tag = b && z ? "R5 beq taken" : "R6 bne taken";
    end else begin
      nxt = exp_pc + 32'd4;
      tag = b ? "R5 fall-through" : (n ? "R6 fall-through" : "R3 sequential");
    end
    tick;
    chk(tag, pc, nxt);
    chk("R9 imem_addr", 32'(imem_addr), 32'(nxt[15:2]));
    exp_pc = nxt;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL R1 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] imms [6];
    imms[0] = 16'h0000; imms[1] = 16'h0001; imms[2] = 16'hFFFF;
    imms[3] = 16'h7FFF; imms[4] = 16'h8000; imms[5] = 16'h0123;
    rst = 1;
    tick;
    tick;
    rst = 0;
    #1;
    chk("R10 reset pc", pc, 32'd0);
    chk("R10 reset phase", 32'(phase), 32'd0);
    chk("R2 reset exec_stb", 32'(exec_stb), 32'd0);
    for (int k = 0; k < 6; k++) begin
      for (int c = 0; c < 16; c++) begin
        slot(c[3], c[2], c[1], c[0], 32'h0001_0000 + 32'(c * 260 + k * 4),
             imms[k], c[0] ^ k[0]);
      end
    end
    tick;
    rst = 1;
    tick;
    rst = 0;
    #1;
    chk("R10 mid-slot reset pc", pc, 32'd0);
    chk("R10 mid-slot reset phase", 32'(phase), 32'd0);
    exp_pc = '0;
    slot(0, 0, 0, 0, 32'd0, 16'd0, 1'b1);
    slot(0, 1, 0, 1, 32'd0, 16'hFFFF, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule